// File: doc/BRIEF.md
# Single-Line Read Cache with CPU Stall

This block sits between a fast 8-bit processor port and a burst memory sequencer. It keeps one line of eight 16-bit words (sixteen bytes) from the most recent burst, together with the line-aligned address it came from. A read that lands inside that line is answered at once from the stored words. A read outside it stalls the processor with a wait signal, asks the sequencer for one burst, and stores the eight words as they arrive. It then drops the wait and returns the selected byte.

Fills from this port have the lowest memory priority, so the sequencer may answer late and with gaps between words. The cache holds its request and the stall for as long as the fill takes. Writes never stall. Each write is passed downstream as a one-cycle posted write. If the write lands in the held line, that byte in the line is also updated, so the next read sees the new value.

Top module: `line_cache`

## Requirements
- R1: After reset the line is invalid, `cpuWait`, `fillReq` and `postWr` are low, and the first read always misses.
- R2: A read whose line address (`cpuAddr[15:4]`) does not match a valid line raises `cpuWait` in the same cycle. From the next cycle `fillReq` is high and `fillAddr` equals `cpuAddr[15:4]`.
- R3: During a fill, `fillReq` and `cpuWait` stay high until the eighth word is taken. Words arrive on `fillData`, qualified by `fillValid`, in word order 0 to 7, with any number of idle cycles between them.
- R4: In the cycle after the eighth word is taken, `fillReq` and `cpuWait` are low. `cpuRdata` then gives the byte picked by `cpuAddr[3:1]` (word) and `cpuAddr[0]` (0 = bits 7:0, 1 = bits 15:8).
- R5: A read inside the valid line gets no `cpuWait` and no fill, and returns the stored byte in the same cycle.
- R6: A read to another line misses, refills the line from that line's burst, and replaces the previous contents.
- R7: A write never raises `cpuWait`. One cycle after `cpuWr`, the port gives a single-cycle `postWr` pulse, with `postAddr` and `postData` equal to the write's address and byte.
- R8: A write that hits the line replaces that byte in the line, so a following read returns the new value with no wait. A write that misses leaves the line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuRd | input | 1 | Read request, held until `cpuWait` is low |
| cpuWr | input | 1 | Write strobe, one cycle per byte |
| cpuAddr | input | 16 | Byte address |
| cpuWdata | input | 8 | Write byte |
| cpuRdata | output | 8 | Read byte, valid while `cpuRd` is high and `cpuWait` is low |
| cpuWait | output | 1 | Stall request to the processor |
| fillReq | output | 1 | Burst fill request, held until the last word |
| fillAddr | output | 12 | Line address of the requested burst |
| fillValid | input | 1 | A fill word is present this cycle |
| fillData | input | 16 | Fill word |
| postWr | output | 1 | Posted write strobe to the write queue |
| postAddr | output | 16 | Posted write address |
| postData | output | 8 | Posted write byte |

## Verification
The hardest case to reach from the ports is a slow, gapped fill. In that case the stall must hold through idle cycles between words, and no partly filled line may be served. The bench plays the sequencer itself. It inserts a chosen number of idle cycles before each word and checks the wait and request at every gap. It then sweeps all sixteen byte offsets of each filled line against a line model computed in the bench, before and after writes that hit and writes that miss.

// File: rtl/line_cache_pkg.sv
package line_cache_pkg;
  // strobes from the control to the datapath
  typedef struct packed {
    logic startFill;   // latch requested tag, drop validity
    logic captureWord; // store fillData at beatIdx
    logic finishFill;  // last word stored, line becomes valid
  } fillCtl_t;
endpackage

// File: rtl/line_cache_data.sv
module line_cache_data
  import line_cache_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WORDS  = 8,
  localparam int IDX_W = $clog2(WORDS),
  localparam int OFF_W = IDX_W + 1,
  localparam int TAG_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  fillCtl_t          ctl,
  input  logic [IDX_W-1:0]  beatIdx,
  input  logic [15:0]       fillData,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWr,
  input  logic [7:0]        cpuWdata,
  output logic              hit,
  output logic [7:0]        rdata,
  output logic [TAG_W-1:0]  fillTag
);
  logic [15:0]      lineWords [WORDS];
  logic [TAG_W-1:0] lineTag;
  logic             lineValid;

  logic [TAG_W-1:0] reqTag;
  logic [IDX_W-1:0] wordSel;
  logic             byteSel;

  assign reqTag  = cpuAddr[ADDR_W-1:OFF_W];
  assign wordSel = cpuAddr[OFF_W-1:1];
  assign byteSel = cpuAddr[0];
  assign hit     = lineValid && (lineTag == reqTag);
  assign rdata   = byteSel ? lineWords[wordSel][15:8] : lineWords[wordSel][7:0];
  assign fillTag = lineTag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineValid <= 1'b0;
      lineTag   <= '0;
    end else if (ctl.startFill) begin
      lineValid <= 1'b0;
      lineTag   <= reqTag;
    end else if (ctl.finishFill) begin
      lineValid <= 1'b1;
    end
  end

  for (genvar i = 0; i < WORDS; i++) begin : gWord
    always_ff @(posedge clk) begin
      if (!rstN) begin
        lineWords[i] <= '0;
      end else if (ctl.captureWord && beatIdx == IDX_W'(i)) begin
        lineWords[i] <= fillData;
      end else if (cpuWr && hit && wordSel == IDX_W'(i)) begin
        if (byteSel) lineWords[i][15:8] <= cpuWdata;
        else         lineWords[i][7:0]  <= cpuWdata;
      end
    end
  end

  assert_fill_drops_line_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.startFill |=> !lineValid);
  assert_line_valid_after_fill_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.finishFill |=> lineValid && $stable(lineTag));
  assert_tag_kept_R5: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.startFill |=> $stable(lineTag));
endmodule

// File: rtl/line_cache_ctrl.sv
module line_cache_ctrl
  import line_cache_pkg::*;
#(
  parameter int WORDS  = 8,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuRd,
  input  logic             hit,
  input  logic             fillValid,
  output fillCtl_t         ctl,
  output logic [IDX_W-1:0] beatIdx,
  output logic             fillReq,
  output logic             cpuWait
);
  typedef enum logic {IDLE, FILL} state_t;
  state_t state;

  assign cpuWait         = cpuRd && !hit;
  assign fillReq         = (state == FILL);
  assign ctl.startFill   = (state == IDLE) && cpuRd && !hit;
  assign ctl.captureWord = (state == FILL) && fillValid;
  assign ctl.finishFill  = ctl.captureWord && (beatIdx == IDX_W'(WORDS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= IDLE;
      beatIdx <= '0;
    end else begin
      if (ctl.startFill) begin
        state   <= FILL;
        beatIdx <= '0;
      end else if (ctl.finishFill) begin
        state   <= IDLE;
        beatIdx <= '0;
      end else if (ctl.captureWord) begin
        beatIdx <= beatIdx + 1'b1;
      end
    end
  end

  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    (fillReq && !ctl.finishFill) |=> fillReq);
  assert_wait_in_fill_R3: assert property (@(posedge clk) disable iff (!rstN)
    (fillReq && cpuRd) |-> cpuWait);
  assert_req_released_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.finishFill |=> !fillReq);
  assert_miss_starts_fill_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWait && !fillReq) |=> fillReq);
endmodule

// File: rtl/line_cache.sv
module line_cache
  import line_cache_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WORDS  = 8,
  localparam int IDX_W = $clog2(WORDS),
  localparam int OFF_W = IDX_W + 1,
  localparam int TAG_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuRd,
  input  logic              cpuWr,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [7:0]        cpuWdata,
  output logic [7:0]        cpuRdata,
  output logic              cpuWait,
  output logic              fillReq,
  output logic [TAG_W-1:0]  fillAddr,
  input  logic              fillValid,
  input  logic [15:0]       fillData,
  output logic              postWr,
  output logic [ADDR_W-1:0] postAddr,
  output logic [7:0]        postData
);
  fillCtl_t         ctl;
  logic [IDX_W-1:0] beatIdx;
  logic             hit;

  line_cache_ctrl #(.WORDS(WORDS)) ctrl (
    .clk, .rstN, .cpuRd, .hit, .fillValid,
    .ctl, .beatIdx, .fillReq, .cpuWait
  );

  line_cache_data #(.ADDR_W(ADDR_W), .WORDS(WORDS)) data (
    .clk, .rstN, .ctl, .beatIdx, .fillData, .cpuAddr, .cpuWr, .cpuWdata,
    .hit, .rdata(cpuRdata), .fillTag(fillAddr)
  );

  // posted write: one registered pulse toward the downstream write queue
  always_ff @(posedge clk) begin
    if (!rstN) begin
      postWr   <= 1'b0;
      postAddr <= '0;
      postData <= '0;
    end else begin
      postWr <= cpuWr;
      if (cpuWr) begin
        postAddr <= cpuAddr;
        postData <= cpuWdata;
      end
    end
  end

  assert_write_posted_R7: assert property (@(posedge clk) disable iff (!rstN)
    cpuWr |=> postWr && postAddr == $past(cpuAddr) && postData == $past(cpuWdata));
  assert_write_no_stall_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && !cpuRd) |-> !cpuWait);
endmodule

// File: tb/line_cache_test.sv
module line_cache_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuRd = 1'b0, cpuWr = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuWdata = '0;
  logic [7:0]  cpuRdata;
  logic        cpuWait, fillReq, postWr;
  logic [11:0] fillAddr;
  logic        fillValid = 1'b0;
  logic [15:0] fillData = '0;
  logic [15:0] postAddr;
  logic [7:0]  postData;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // bench model of the held line
  logic [7:0]  expLine [16];
  logic [11:0] expTag = '0;
  bit          expValid = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  line_cache uut (
    .clk, .rstN, .cpuRd, .cpuWr, .cpuAddr, .cpuWdata, .cpuRdata, .cpuWait,
    .fillReq, .fillAddr, .fillValid, .fillData, .postWr, .postAddr, .postData
  );

  function automatic logic [15:0] memWord(input logic [11:0] t, input int i);
    logic [7:0] hi, lo;
    hi = 8'(int'(t) * 7 + i * 29 + 3);
    lo = 8'(int'(t) * 13 + i * 3 + 1);
    return {hi, lo};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic readByte(input logic [15:0] a, input int gap, input bit expMiss);
    @(negedge clk);
    cpuRd = 1'b1; cpuAddr = a;
    #1;
    check(cpuWait == expMiss, expMiss ? "R2 wait on miss" : "R5 no wait on hit",
          int'(cpuWait), int'(expMiss));
    if (expMiss) begin
      @(negedge clk);
      check(fillReq == 1'b1, "R2 fillReq", int'(fillReq), 1);
      check(fillAddr == a[15:4], "R2 fillAddr", int'(fillAddr), int'(a[15:4]));
      for (int i = 0; i < 8; i++) begin
        for (int g = 0; g < gap; g++) begin
          check(cpuWait && fillReq, "R3 held in gap", int'({cpuWait, fillReq}), 3);
          @(negedge clk);
        end
        fillValid = 1'b1; fillData = memWord(a[15:4], i);
        @(negedge clk);
        fillValid = 1'b0;
      end
      for (int j = 0; j < 8; j++) begin
        expLine[2*j]   = memWord(a[15:4], j)[7:0];
        expLine[2*j+1] = memWord(a[15:4], j)[15:8];
      end
      expTag = a[15:4]; expValid = 1'b1;
      check(fillReq == 1'b0, "R4 fillReq released", int'(fillReq), 0);
    end else begin
      check(fillReq == 1'b0, "R5 no fill on hit", int'(fillReq), 0);
    end
    check(cpuWait == 1'b0, "R4 wait released", int'(cpuWait), 0);
    check(cpuRdata == expLine[a[3:0]], "R4 byte select", int'(cpuRdata), int'(expLine[a[3:0]]));
    cpuRd = 1'b0;
  endtask

  task automatic writeByte(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpuWr = 1'b1; cpuAddr = a; cpuWdata = d;
    #1;
    check(cpuWait == 1'b0, "R7 write no stall", int'(cpuWait), 0);
    if (expValid && a[15:4] == expTag) expLine[a[3:0]] = d;
    @(negedge clk);
    cpuWr = 1'b0;
    check(postWr == 1'b1, "R7 postWr", int'(postWr), 1);
    check(postAddr == a, "R7 postAddr", int'(postAddr), int'(a));
    check(postData == d, "R7 postData", int'(postData), int'(d));
    @(negedge clk);
    check(postWr == 1'b0, "R7 single pulse", int'(postWr), 0);
  endtask

  initial begin
    for (int k = 0; k < 16; k++) expLine[k] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(cpuWait == 1'b0, "R1 reset wait", int'(cpuWait), 0);
    check(fillReq == 1'b0, "R1 reset fillReq", int'(fillReq), 0);
    check(postWr == 1'b0, "R1 reset postWr", int'(postWr), 0);
    // R1: first read misses even at address zero, where the reset tag is zero too
    readByte(16'h0000, 0, 1'b1);
    // R5, R4: sweep every byte of the line
    for (int o = 0; o < 16; o++) readByte(16'h0000 | 16'(o), 0, 1'b0);
    // R6, R3: another line, gapped fill
    readByte(16'h1235, 2, 1'b1);
    for (int o = 0; o < 16; o++) readByte(16'h1230 | 16'(o), 0, 1'b0);
    // R6: back to the first line, longer gaps
    readByte(16'h000A, 3, 1'b1);
    readByte(16'h0001, 0, 1'b0);
    // R8: write hits, low and high bytes
    writeByte(16'h0003, 8'hA5);
    writeByte(16'h0006, 8'h3C);
    readByte(16'h0003, 0, 1'b0);
    readByte(16'h0006, 0, 1'b0);
    readByte(16'h0002, 0, 1'b0);
    // R8: a write miss leaves the line as it was
    writeByte(16'h4567, 8'hEE);
    for (int o = 0; o < 16; o++) readByte(16'h0000 | 16'(o), 0, 1'b0);
    // R7: a write while idle raises no wait
    @(negedge clk);
    check(cpuWait == 1'b0 && fillReq == 1'b0, "R7 idle after writes", int'({cpuWait, fillReq}), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule